// File: doc/BRIEF.md
# Ramped Channel Attenuator with Soft Mute

This block keeps the effective attenuation code of one audio channel and walks it toward a programmed target code, paced by the sample strobe. The code is read as a level in half-decibel steps: code 255 is unity gain, and each code below it takes away another 0.5 dB. Any code of 128 or lower means the channel is fully silent. The code never jumps. It moves by one step on every eighth sample strobe, so a level change reaches the signal path as a slow, click-free slope.

A soft-mute request uses the same ramp. The code slides down from where it is to the silent floor. When the request is released, the code climbs back to whatever target is programmed at that moment. A separate disable bit forces the output sample to zero (the bipolar mid level) at once, and it leaves the ramp state alone. The gain table and the multiplier that use the code sit downstream of this block.

Top module: `ramp_atten`

## Requirements
- R1: After reset, `effCode` is 255, `mutedFlag` is 0 and `forceZero` follows `dacDisable` only.
- R2: `mutedFlag` is 1 exactly when `effCode` equals 128, the silent floor. In that state `forceZero` is also 1.
- R3: A pace counter counts cycles with `sampleStb` high, modulo 8. `effCode` can change only on the clock edge where the eighth counted strobe since the last step is taken. Cycles without a strobe do not advance the counter.
- R4: On each step, `effCode` moves by exactly one code toward the goal. The goal is `targetCode` when `muteReq` is low. When `effCode` already equals the goal, the step leaves it unchanged.
- R5: A `targetCode` from 0 to 128 gives the goal 128. `effCode` never goes below 128.
- R6: While `muteReq` is high, the goal is 128, so `effCode` ramps down one code per step from its current value and then holds at 128.
- R7: After `muteReq` is released, `effCode` ramps up or down one code per step to the `targetCode` present at each step.
- R8: A change of `targetCode` during a ramp is used at the next step. It does not reset the pace counter.
- R9: `forceZero` is high whenever `dacDisable` is high, in the same cycle. `dacDisable` does not change `effCode` or the pacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | One-cycle pulse per sample period |
| targetCode | input | 8 | Programmed attenuation code (255 = 0 dB) |
| muteReq | input | 1 | Soft-mute request |
| dacDisable | input | 1 | Forces the output sample to zero |
| effCode | output | 8 | Current effective attenuation code |
| mutedFlag | output | 1 | Effective code is at the silent floor |
| forceZero | output | 1 | Output sample must be replaced by zero |

## Verification
The bench checks the step on the eighth strobe. A counter that is off by one, or that counts plain clock cycles, would move the code too early, too late or during gaps between strobes. It checks targets of 128 and below, where a design without the clamp would run the code down to zero and never raise the muted flag. It checks target changes in the middle of a ramp, where a design that restarts pacing would stall the next step. It checks mute release, where a design that returns to a stale target would stop at the wrong level. Random targets, mute toggles, gaps between strobes and disable pulses are compared against a bench model on every cycle.

// File: rtl/ramp_atten_pkg.sv
package ramp_atten_pkg;
  // strobes from the pacing control to the code register
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } rampCmd_t;
endpackage

// File: rtl/ramp_atten_ctrl.sv
module ramp_atten_ctrl
  import ramp_atten_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int PACE_DIV   = 8,
  parameter int FLOOR_CODE = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleStb,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              muteReq,
  input  logic [CODE_W-1:0] effCode,
  output rampCmd_t          cmd
);
  localparam int PACE_W = (PACE_DIV > 1) ? $clog2(PACE_DIV) : 1;
  localparam logic [PACE_W-1:0] PACE_LAST = PACE_W'(PACE_DIV - 1);
  localparam logic [CODE_W-1:0] FLOOR_V = CODE_W'(FLOOR_CODE);

  logic [PACE_W-1:0] paceCnt;
  logic              paceWrap;
  logic [CODE_W-1:0] goalCode;

  assign paceWrap = sampleStb && (paceCnt == PACE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) paceCnt <= '0;
    else if (sampleStb) paceCnt <= paceWrap ? '0 : paceCnt + 1'b1;
  end

  always_comb begin
    if (muteReq || (targetCode < FLOOR_V)) goalCode = FLOOR_V;
    else goalCode = targetCode;
  end

  always_comb begin
    cmd.stepUp   = paceWrap && (effCode < goalCode);
    cmd.stepDown = paceWrap && (effCode > goalCode);
  end

  // R4: the two step strobes are never raised together
  a_r4_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.stepUp && cmd.stepDown));
endmodule

// File: rtl/ramp_atten_dp.sv
module ramp_atten_dp
  import ramp_atten_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int FLOOR_CODE = 128,
  parameter int UNITY_CODE = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rampCmd_t          cmd,
  output logic [CODE_W-1:0] effCode,
  output logic              mutedFlag
);
  localparam logic [CODE_W-1:0] FLOOR_V = CODE_W'(FLOOR_CODE);
  localparam logic [CODE_W-1:0] UNITY_V = CODE_W'(UNITY_CODE);

  logic [CODE_W-1:0] codeQ;

  always_ff @(posedge clk) begin
    if (!rst_n) codeQ <= UNITY_V;
    else if (cmd.stepUp) codeQ <= codeQ + 1'b1;
    else if (cmd.stepDown) codeQ <= codeQ - 1'b1;
  end

  assign effCode   = codeQ;
  assign mutedFlag = (codeQ == FLOOR_V);

  // R5: the register never leaves the floor..unity range
  a_r5_floor_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (codeQ >= FLOOR_V) && (codeQ <= UNITY_V));

  // R4: one code per clock at most
  a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, codeQ} == {1'b0, $past(codeQ)}) ||
    ({1'b0, codeQ} == {1'b0, $past(codeQ)} + 1'b1) ||
    ({1'b0, codeQ} + 1'b1 == {1'b0, $past(codeQ)}));
endmodule

// File: rtl/ramp_atten.sv
module ramp_atten
  import ramp_atten_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int PACE_DIV   = 8,
  parameter int FLOOR_CODE = 128,
  parameter int UNITY_CODE = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleStb,
  input  logic [CODE_W-1:0] targetCode,
  input  logic              muteReq,
  input  logic              dacDisable,
  output logic [CODE_W-1:0] effCode,
  output logic              mutedFlag,
  output logic              forceZero
);
  rampCmd_t cmd;

  ramp_atten_ctrl #(.CODE_W(CODE_W), .PACE_DIV(PACE_DIV), .FLOOR_CODE(FLOOR_CODE)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .targetCode(targetCode),
    .muteReq(muteReq), .effCode(effCode), .cmd(cmd)
  );

  ramp_atten_dp #(.CODE_W(CODE_W), .FLOOR_CODE(FLOOR_CODE), .UNITY_CODE(UNITY_CODE)) dp_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .effCode(effCode), .mutedFlag(mutedFlag)
  );

  assign forceZero = dacDisable || mutedFlag;

  // R3: the code only moves on an edge that took a sample strobe
  a_r3_paced_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (effCode != $past(effCode)) |-> $past(sampleStb));

  // R6: while mute is held the code can only fall
  a_r6_mute_falls: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(muteReq) && (effCode != $past(effCode))) |-> (effCode < $past(effCode)));
endmodule

// File: tb/ramp_atten_tb_top.sv
`timescale 1ns/1ps
module ramp_atten_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sampleStb = 1'b0;
  logic [7:0] targetCode = 8'd255;
  logic       muteReq = 1'b0;
  logic       dacDisable = 1'b0;
  logic [7:0] effCode;
  logic       mutedFlag;
  logic       forceZero;

  int nChecks = 0;
  int nFails  = 0;
  int mPace   = 0;
  int mCode   = 255;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  ramp_atten dut_i (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .targetCode(targetCode),
    .muteReq(muteReq), .dacDisable(dacDisable),
    .effCode(effCode), .mutedFlag(mutedFlag), .forceZero(forceZero)
  );

  function automatic int goalOf(int tgt, bit mute);
    if (mute || tgt < 128) return 128;
    return tgt;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    check({tag, " effCode"}, effCode, mCode);
    check({tag, " mutedFlag"}, mutedFlag, (mCode == 128));
    check({tag, " forceZero"}, forceZero, (dacDisable || mCode == 128));
  endtask

  // one clock with the current inputs; model advances with the edge
  task automatic tick(bit stb);
    int g;
    sampleStb = stb;
    @(posedge clk);
    if (stb) begin
      if (mPace == 7) begin
        mPace = 0;
        g = goalOf(targetCode, muteReq);
        if (mCode < g) mCode++;
        else if (mCode > g) mCode--;
      end else mPace++;
    end
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkAll("R1 reset");

    // R3: seven strobes and idle gaps leave the code at 255
    targetCode = 8'd200;
    strobes(7);
    repeat (5) tick(1'b0);
    check("R3 no step before 8th strobe", effCode, 255);
    tick(1'b1);
    check("R4 first step down by one", effCode, 254);
    strobes(8);
    check("R3 second step after 8 more", effCode, 253);

    // R8: mid-ramp target change, pace counter not restarted
    strobes(3);
    targetCode = 8'd255;
    strobes(5);
    check("R8 reversal at next wrap", effCode, 254);
    strobes(8);
    check("R10 holds at goal", effCode, 255);
    strobes(8);
    check("R10 stays at goal", effCode, 255);

    // R5: target in mute range clamps at 128
    targetCode = 8'd5;
    strobes(8 * 130);
    check("R5 clamp at 128", effCode, 128);
    check("R2 muted at floor", mutedFlag, 1);
    check("R2 forceZero at floor", forceZero, 1);
    targetCode = 8'd130;
    strobes(16);
    check("R2 unmuted above floor", mutedFlag, 0);
    check("R7 ramp up to 130", effCode, 130);

    // R6 / R7: mute and release
    targetCode = 8'd140;
    strobes(8 * 10);
    muteReq = 1'b1;
    strobes(8 * 5);
    check("R6 mute ramps down", effCode, 135);
    strobes(8 * 10);
    check("R6 mute holds floor", effCode, 128);
    targetCode = 8'd133;
    muteReq = 1'b0;
    strobes(8 * 10);
    check("R7 release to current target", effCode, 133);

    // R9: disable forces zero without touching the code
    dacDisable = 1'b1;
    @(negedge clk);
    check("R9 forceZero with disable", forceZero, 1);
    targetCode = 8'd134;
    strobes(8);
    check("R9 ramp continues under disable", effCode, 134);
    dacDisable = 1'b0;
    @(negedge clk);
    check("R9 forceZero released", forceZero, 0);

    // random mix, checked every cycle
    for (int i = 0; i < 20000; i++) begin
      r = $urandom_range(0, 999);
      if (r < 8) targetCode = 8'($urandom_range(0, 255));
      if (r >= 990) muteReq = ~muteReq;
      dacDisable = ($urandom_range(0, 19) == 0);
      tick($urandom_range(0, 1) == 1);
      checkAll("R4 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule